// File: doc/BRIEF.md
# Polarity-Configurable RGB Video Capture

This block receives a synchronous pixel stream made of frame sync, line sync, a dot clock, a data-enable strobe and a pixel bus of 6, 16 or 18 bits. Each of the four control signals has its own polarity setting. The block samples the bus on the chosen dot-clock edge and widens every pixel to 18-bit RGB (6:6:6). It then presents each pixel as a one-cycle strobe with its column and line number and with start-of-line and start-of-frame flags.

The dot clock is an ordinary input. It is sampled by the system clock `clk` and edge-detected there, so `clk` must run several times faster than the dot clock. A separate pulse marks the first dot clock of the horizontal front porch. A host can use it to start writes in step with the display scan. The target raster is 240 pixels by 320 lines. The position counters wrap at their parameter widths.

Top module: `rgb_capture`

## Requirements
- R1: An active dot-clock edge is detected on the first `clk` rising edge at which the polarity-corrected dot clock is high after having been low. Every completed pixel raises `px_valid` for exactly one `clk` cycle, starting on the `clk` edge after that detection.
- R2: With `pol_dot`=0 the active edge is the rising edge of `dotclk_in`. With `pol_dot`=1 it is the falling edge.
- R3: Each of `vsync_in`, `hsync_in` and `de_in` is active low when its polarity bit is 0 and active high when the bit is 1. Pixel data is taken only on dot edges where data-enable is active.
- R4: With `bus_mode`=2'b00 (and also 2'b11), one transfer carries one pixel, and `px_rgb` equals `pix_bus[17:0]`. Red is in bits 17:12, green in 11:6 and blue in 5:0.
- R5: With `bus_mode`=2'b01, a pixel is 5:6:5 on the pins. Red comes from bus 17:13, green from 11:6 and blue from 5:1. Bits 12 and 0 are ignored. Red and blue are widened by repeating their MSB as the new LSB.
- R6: With `bus_mode`=2'b10, each pixel takes three transfers on bus 17:12, in the order red, green, blue. The transfer phase returns to red at every line-sync start.
- R7: `px_col` is the pixel's position in its line. The count restarts at 0 on the dot edge where line sync becomes active and advances once per completed pixel.
- R8: `px_row` is 0 for the first active line after frame sync becomes active, and it advances by one at each front porch.
- R9: `px_sol` accompanies a valid pixel whose column is 0. `px_sof` accompanies a valid pixel whose column and line are both 0.
- R10: `fp_pulse` goes high on the dot edge where data-enable becomes inactive after being active. It stays high until the next active dot edge, which clears it unless that edge is also such a transition.
- R11: While `rst_n` is low, all outputs are 0, and the sampled sync and enable history is cleared to the inactive state. The first dot edge after reset needs a fresh inactive-to-active transition of the dot clock.
- R12: On a dot edge where line sync becomes active, no pixel data is taken, even if data-enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_vs | input | 1 | Frame sync polarity, 1 = active high |
| pol_hs | input | 1 | Line sync polarity, 1 = active high |
| pol_dot | input | 1 | Dot clock polarity, 1 = capture on falling edge |
| pol_de | input | 1 | Data-enable polarity, 1 = active high |
| bus_mode | input | 2 | 00/11 = 18-bit, 01 = 16-bit, 10 = 6-bit |
| vsync_in | input | 1 | Frame sync pin |
| hsync_in | input | 1 | Line sync pin |
| dotclk_in | input | 1 | Dot clock pin |
| de_in | input | 1 | Data-enable pin |
| pix_bus | input | 18 | Pixel data pins |
| px_valid | output | 1 | One-cycle strobe for a completed pixel |
| px_rgb | output | 18 | Pixel as 6:6:6 RGB, red in the MSBs |
| px_col | output | XW | Column of the pixel |
| px_row | output | YW | Line of the pixel |
| px_sol | output | 1 | Strobe: first pixel of a line |
| px_sof | output | 1 | Strobe: first pixel of a frame |
| fp_pulse | output | 1 | High for one dot clock at front porch start |

## Verification
A dot edge is detected at the first `clk` edge after the pin reaches its active level. Pixel strobes, colours, positions and flags then appear on the next `clk` edge, and `fp_pulse` changes at the same edge and holds until the following dot edge. The bench drives every pin on the falling edge of `clk` and runs a behavioural model on each rising edge. It compares every output on the falling edge, so model and design are checked against the same registered instant with no race. The stimulus covers the three bus widths, inverted and mixed polarities, a 6-bit line cut off mid-pixel, and a line sync that coincides with active enable.

// File: rtl/rgb_capture.sv
module rgb_capture #(
  parameter int XW = 9,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pol_vs,
  input  logic          pol_hs,
  input  logic          pol_dot,
  input  logic          pol_de,
  input  logic [1:0]    bus_mode,
  input  logic          vsync_in,
  input  logic          hsync_in,
  input  logic          dotclk_in,
  input  logic          de_in,
  input  logic [17:0]   pix_bus,
  output logic          px_valid,
  output logic [17:0]   px_rgb,
  output logic [XW-1:0] px_col,
  output logic [YW-1:0] px_row,
  output logic          px_sol,
  output logic          px_sof,
  output logic          fp_pulse
);

  localparam logic [1:0] MODE_W16 = 2'b01;
  localparam logic [1:0] MODE_W6  = 2'b10;

  logic          dot_q, hs_q, vs_q, de_q;
  logic [1:0]    ph;
  logic [5:0]    r_hold, g_hold;
  logic [XW-1:0] col;
  logic [YW-1:0] row;
  logic [17:0]   rgb_now;

  wire dot_n  = dotclk_in ^ pol_dot;
  wire ev     = dot_n & ~dot_q;
  wire hs_a   = hsync_in ~^ pol_hs;
  wire vs_a   = vsync_in ~^ pol_vs;
  wire de_a   = de_in ~^ pol_de;
  wire hs_go  = hs_a & ~hs_q;
  wire vs_go  = vs_a & ~vs_q;
  wire de_end = de_q & ~de_a;
  wire six    = (bus_mode == MODE_W6);
  wire last   = !six || (ph == 2'd2);

  always_comb begin
    if (six)
      rgb_now = {r_hold, g_hold, pix_bus[17:12]};
    else if (bus_mode == MODE_W16)
      rgb_now = {pix_bus[17:13], pix_bus[17], pix_bus[11:6], pix_bus[5:1], pix_bus[5]};
    else
      rgb_now = pix_bus;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot_q    <= 1'b1;
      hs_q     <= 1'b0;
      vs_q     <= 1'b0;
      de_q     <= 1'b0;
      ph       <= '0;
      r_hold   <= '0;
      g_hold   <= '0;
      col      <= '0;
      row      <= '0;
      px_valid <= 1'b0;
      px_rgb   <= '0;
      px_col   <= '0;
      px_row   <= '0;
      px_sol   <= 1'b0;
      px_sof   <= 1'b0;
      fp_pulse <= 1'b0;
    end else begin
      dot_q    <= dot_n;
      px_valid <= 1'b0;
      px_sol   <= 1'b0;
      px_sof   <= 1'b0;
      if (ev) begin
        hs_q     <= hs_a;
        vs_q     <= vs_a;
        de_q     <= de_a;
        fp_pulse <= de_end;
        if (vs_go)       row <= '0;
        else if (de_end) row <= row + 1'b1;
        if (hs_go) begin
          col <= '0;
          ph  <= '0;
        end else if (de_a) begin
          if (six && ph == 2'd0) r_hold <= pix_bus[17:12];
          if (six && ph == 2'd1) g_hold <= pix_bus[17:12];
          if (last) begin
            px_valid <= 1'b1;
            px_rgb   <= rgb_now;
            px_col   <= col;
            px_row   <= row;
            px_sol   <= (col == '0);
            px_sof   <= (col == '0) && (row == '0);
            col      <= col + 1'b1;
            ph       <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> !px_valid); // R1
  AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> $past(ev)); // R1
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ph != 2'd3); // R6
  AST_SOL_AT_COL0: assert property (@(posedge clk) disable iff (!rst_n)
    px_sol |-> (px_valid && px_col == '0)); // R9
  AST_SOF_WITH_SOL: assert property (@(posedge clk) disable iff (!rst_n)
    px_sof |-> (px_sol && px_row == '0)); // R9
  AST_FP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev |=> $stable(fp_pulse)); // R10

endmodule

// File: tb/tb_rgb_capture.sv
module tb_rgb_capture;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        pol_vs = 0, pol_hs = 0, pol_dot = 0, pol_de = 0;
  logic [1:0]  bus_mode = 2'b00;
  logic        vsync_in = 1, hsync_in = 1, dotclk_in = 0, de_in = 1;
  logic [17:0] pix_bus = '0;
  logic        px_valid, px_sol, px_sof, fp_pulse;
  logic [17:0] px_rgb;
  logic [8:0]  px_col, px_row;

  rgb_capture dut (
    .clk(clk), .rst_n(rst_n), .pol_vs(pol_vs), .pol_hs(pol_hs), .pol_dot(pol_dot),
    .pol_de(pol_de), .bus_mode(bus_mode), .vsync_in(vsync_in), .hsync_in(hsync_in),
    .dotclk_in(dotclk_in), .de_in(de_in), .pix_bus(pix_bus), .px_valid(px_valid),
    .px_rgb(px_rgb), .px_col(px_col), .px_row(px_row), .px_sol(px_sol),
    .px_sof(px_sof), .fp_pulse(fp_pulse)
  );

  int n_chk = 0, n_bad = 0;
  bit checking = 0, done = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  bit m_dq, m_hs, m_vs, m_de, e_valid, e_sol, e_sof, e_fp;
  int m_ph, m_col, m_row, e_col, e_row;
  logic [5:0]  m_r, m_g;
  logic [17:0] e_rgb;

  function automatic void emit(logic [17:0] v);
    e_valid = 1; e_rgb = v; e_col = m_col; e_row = m_row;
    e_sol = (m_col == 0); e_sof = (m_col == 0) && (m_row == 0);
    m_col++;
  endfunction

  always @(posedge clk) begin : model
    bit dn, ev, hs, vs, de;
    if (!rst_n) begin
      m_dq = 1; m_hs = 0; m_vs = 0; m_de = 0; m_ph = 0; m_col = 0; m_row = 0;
      e_valid = 0; e_sol = 0; e_sof = 0; e_fp = 0;
    end else begin
      dn = dotclk_in ^ pol_dot;
      ev = dn && !m_dq;
      m_dq = dn;
      e_valid = 0; e_sol = 0; e_sof = 0;
      if (ev) begin
        hs = (hsync_in == pol_hs); vs = (vsync_in == pol_vs); de = (de_in == pol_de);
        e_fp = m_de && !de;
        if (hs && !m_hs) begin
          m_col = 0; m_ph = 0;
        end else if (de) begin
          if (bus_mode == 2'b10) begin
            if (m_ph == 0) begin m_r = pix_bus[17:12]; m_ph = 1; end
            else if (m_ph == 1) begin m_g = pix_bus[17:12]; m_ph = 2; end
            else begin emit({m_r, m_g, pix_bus[17:12]}); m_ph = 0; end
          end else if (bus_mode == 2'b01)
            emit({pix_bus[17:13], pix_bus[17], pix_bus[11:6], pix_bus[5:1], pix_bus[5]});
          else
            emit(pix_bus);
        end
        if (vs && !m_vs) m_row = 0;
        else if (m_de && !de) m_row++;
        m_hs = hs; m_vs = vs; m_de = de;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking && !done) begin
      chk(px_valid == e_valid, "R1 R2 R3 px_valid", px_valid, e_valid);
      chk(fp_pulse == e_fp, "R10 fp_pulse", fp_pulse, e_fp);
      if (e_valid) begin
        chk(px_rgb == e_rgb, bus_mode == 2'b10 ? "R6 rgb" : bus_mode == 2'b01 ? "R5 rgb" : "R4 rgb",
            px_rgb, e_rgb);
        chk(px_col == e_col[8:0], "R7 R12 px_col", px_col, e_col);
        chk(px_row == e_row[8:0], "R8 px_row", px_row, e_row);
        chk(px_sol == e_sol, "R9 px_sol", px_sol, e_sol);
        chk(px_sof == e_sof, "R9 px_sof", px_sof, e_sof);
      end
    end
  end

  task automatic dot(bit v, bit h, bit e);
    @(negedge clk);
    vsync_in = v ~^ pol_vs; hsync_in = h ~^ pol_hs; de_in = e ~^ pol_de;
    pix_bus = 18'($urandom);
    dotclk_in = pol_dot;
    repeat (2) @(negedge clk);
    dotclk_in = ~pol_dot;
    @(negedge clk);
  endtask

  task automatic frame(int lines, int pix, int beats, int extra, bit clash);
    dot(1, 0, 0); dot(0, 0, 0);
    for (int l = 0; l < lines; l++) begin
      dot(0, 1, clash); dot(0, 0, 0);
      repeat (pix * beats + extra) dot(0, 0, 1);
      dot(0, 0, 0); dot(0, 0, 0);
    end
  endtask

  task automatic start(bit pv, bit ph, bit pd, bit pe, logic [1:0] m);
    checking = 0;
    @(negedge clk);
    rst_n = 0;
    pol_vs = pv; pol_hs = ph; pol_dot = pd; pol_de = pe; bus_mode = m;
    vsync_in = ~pv; hsync_in = ~ph; de_in = ~pe; dotclk_in = pd;
    repeat (3) @(negedge clk);
    chk(px_valid == 0, "R11 px_valid in reset", px_valid, 0);
    chk(fp_pulse == 0, "R11 fp_pulse in reset", fp_pulse, 0);
    chk({px_sol, px_sof} == 0, "R11 flags in reset", {px_sol, px_sof}, 0);
    rst_n = 1;
    checking = 1;
  endtask

  initial begin
    start(0, 0, 0, 0, 2'b00);
    frame(3, 5, 1, 0, 0); frame(2, 4, 1, 0, 0);
    start(1, 1, 1, 1, 2'b01);
    frame(3, 6, 1, 0, 0); frame(2, 3, 1, 0, 1);
    start(0, 1, 0, 1, 2'b10);
    frame(3, 4, 3, 0, 0); frame(2, 2, 3, 2, 0); frame(2, 3, 3, 0, 1);
    start(1, 0, 1, 0, 2'b11);
    frame(2, 4, 1, 0, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule